// File: doc/BRIEF.md
# Indexed RTC Register Port

This block gives a host a two-address window onto a 128-byte space of clock registers and battery-backed storage. The host first writes a 7-bit index to the even address. Accesses to the odd address then read or write the byte that index selects. Most indices are plain storage. The four control registers and the time bytes follow their own access rules.

The calendar and periodic-rate logic sit beside this block. They raise flag set requests and drive the update-in-progress bit. This block merges the requests into the flag register and drives a level interrupt. It exports the rate, oscillator and mode fields and sends a one-cycle load pulse whenever the host changes the time while the clock is running. Read data is registered and is valid in the cycle after the read strobe.

Top module: `rtc_idx_regs`

## Requirements
- R1: After reset, control A (index 10) reads 0x26, control B (index 11) reads 0x02, flags C (index 12) read 0x00 and status D (index 13) reads 0x80. `irq` is low and `time_load` is low.
- R2: A write with `bus_a0`=0 stores `bus_wdata[6:0]` as the index and ignores bit 7. A write with `bus_a0`=1 writes the indexed byte. A read strobe with `bus_a0`=1 returns the indexed byte on `bus_rdata` one cycle later. A read with `bus_a0`=0 returns 0xFF.
- R3: Every index outside 10..13 is plain read/write storage. This includes the alarm bytes at 1, 3 and 5, the time bytes and index 127.
- R4: A write to A stores bits 6:0 and leaves bit 7 (update in progress) unchanged. `rate_sel` shows A[3:0] and `osc_sel` shows A[6:4].
- R5: `uip_set` sets A[7] only while B[7] is 0. `uip_clr` clears A[7]. A write to B with bit 7 set clears A[7].
- R6: Writes to C and D are ignored.
- R7: `flag_set[0]`, `flag_set[1]` and `flag_set[2]` set C bits 4, 5 and 6. C bit 7 is set in the same edge when a request arrives together with its enable in B bit 4, 5 or 6. `irq` follows C bit 7.
- R8: A read of C returns its current value and clears C and `irq` one cycle after the strobe.
- R9: A flag request in the same cycle as a read of C does not appear in that read, but it is held in C for the next read.
- R10: `time_load` pulses for one cycle after an odd-address write to index 0, 2, 4, 6, 7, 8 or 9 while B[7] is 0. It also pulses after a write to B that clears B[7] from 1.
- R11: `ctl_b` always shows the current contents of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | Address bit 0: 0 selects index, 1 selects data |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| flag_set | input | 3 | Flag set requests: bit0 update end, bit1 alarm, bit2 periodic |
| uip_set | input | 1 | Calendar marks an update in progress |
| uip_clr | input | 1 | Calendar marks the update finished |
| rate_sel | output | 4 | Periodic rate field of A |
| osc_sel | output | 3 | Oscillator control field of A |
| ctl_b | output | 8 | Contents of control B |
| irq | output | 1 | Level interrupt |
| time_load | output | 1 | One-cycle pulse: time bytes were changed by the host |

## Verification
A wrong flag register is visible on `irq` one cycle after the request that should have changed it. It is also visible on the next read of index 12, which clears the register. A lost or stale update-in-progress bit shows only when index 10 is read back, so a write to A or B is followed by such a read. A wrong index or a stray write into storage is visible only when that byte is read, so each pattern is read back right after it is written.

// File: rtl/rtc_idx_regs.sv
module rtc_idx_regs #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_a0,
  input  logic          bus_we,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [2:0]    flag_set,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [3:0]    rate_sel,
  output logic [2:0]    osc_sel,
  output logic [DW-1:0] ctl_b,
  output logic          irq,
  output logic          time_load
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_A = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(12);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(13);
  localparam logic [DW-1:0] RST_A = DW'(8'h26);
  localparam logic [DW-1:0] RST_B = DW'(8'h02);
  localparam logic [DW-1:0] VAL_D = DW'(8'h80);

  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg_a, reg_b, reg_c, rd_mux;
  logic [DW-1:0]    mem [DEPTH];

  wire wr_odd  = bus_we & bus_a0;
  wire wr_even = bus_we & ~bus_a0;
  wire rd_odd  = bus_rd & bus_a0;
  wire hit_a   = idx == IX_A;
  wire hit_b   = idx == IX_B;
  wire hit_c   = idx == IX_C;
  wire hit_d   = idx == IX_D;
  wire is_ctl  = hit_a | hit_b | hit_c | hit_d;
  wire is_time = (idx == IDX_W'(0)) | (idx == IDX_W'(2)) | (idx == IDX_W'(4)) |
                 (idx == IDX_W'(6)) | (idx == IDX_W'(7)) | (idx == IDX_W'(8)) |
                 (idx == IDX_W'(9));

  wire       raise = |(flag_set & reg_b[6:4]);
  wire [DW-1:0] c_new = {raise, flag_set, {(DW-4){1'b0}}};

  assign rate_sel = reg_a[3:0];
  assign osc_sel  = reg_a[6:4];
  assign ctl_b    = reg_b;
  assign irq      = reg_c[DW-1];

  always_comb begin
    if (hit_a)      rd_mux = reg_a;
    else if (hit_b) rd_mux = reg_b;
    else if (hit_c) rd_mux = reg_c;
    else if (hit_d) rd_mux = VAL_D;
    else            rd_mux = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (wr_odd && !is_ctl) mem[idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      reg_a     <= RST_A;
      reg_b     <= RST_B;
      reg_c     <= '0;
      bus_rdata <= '0;
      time_load <= 1'b0;
    end else begin
      if (wr_even) idx <= bus_wdata[IDX_W-1:0];

      if (wr_odd && hit_a) reg_a[DW-2:0] <= bus_wdata[DW-2:0];
      if (wr_odd && hit_b && bus_wdata[DW-1]) reg_a[DW-1] <= 1'b0;
      else if (uip_clr)                       reg_a[DW-1] <= 1'b0;
      else if (uip_set && !reg_b[DW-1])       reg_a[DW-1] <= 1'b1;

      if (wr_odd && hit_b) reg_b <= bus_wdata;

      reg_c <= ((rd_odd && hit_c) ? '0 : reg_c) | c_new;

      if (bus_rd) bus_rdata <= bus_a0 ? rd_mux : '1;

      time_load <= wr_odd && ((is_time && !reg_b[DW-1]) ||
                              (hit_b && reg_b[DW-1] && !bus_wdata[DW-1]));
    end
  end
endmodule

// File: rtl/rtc_idx_regs_chk.sv
module rtc_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_a0,
  input logic       bus_we,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [2:0] flag_set,
  input logic       uip_set,
  input logic       uip_clr,
  input logic [6:0] idx,
  input logic [7:0] reg_a,
  input logic [7:0] reg_b,
  input logic [7:0] reg_c,
  input logic       irq
);
  // R5
  uip_set_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && idx == 7'd11 && bus_wdata[7]) |=> !reg_a[7]);

  // R4
  uip_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && idx == 7'd10 && !uip_set && !uip_clr) |=> reg_a[7] == $past(reg_a[7]));

  // R6
  c_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_a0 && idx == 7'd12 && flag_set == 3'b000) |=> reg_c == $past(reg_c));

  // R8
  c_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_a0 && idx == 7'd12 && flag_set == 3'b000) |=> (reg_c == 8'h00 && !irq));

  // R9
  c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_a0 && idx == 7'd12) |=> reg_c[6:4] == $past(flag_set));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_set & reg_b[6:4])) |=> irq);
endmodule

bind rtc_idx_regs rtc_idx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_we(bus_we), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .flag_set(flag_set), .uip_set(uip_set), .uip_clr(uip_clr),
  .idx(idx), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .irq(irq)
);

// File: tb/rtc_idx_regs_tb.sv
module rtc_idx_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a0 = 1'b0, we = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] fset = 3'b000;
  logic       uset = 1'b0, uclr = 1'b0;
  logic [7:0] rdata, ctl_b;
  logic [3:0] rate_sel;
  logic [2:0] osc_sel;
  logic       irq, time_load;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rtc_idx_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_a0(a0), .bus_we(we), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .flag_set(fset), .uip_set(uset),
    .uip_clr(uclr), .rate_sel(rate_sel), .osc_sel(osc_sel), .ctl_b(ctl_b),
    .irq(irq), .time_load(time_load)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic addr, logic [7:0] d);
    @(negedge clk); a0 = addr; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_raw(logic addr, output logic [7:0] v);
    @(negedge clk); a0 = addr; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic rd_idx(logic [7:0] i, output logic [7:0] v);
    wr(1'b0, i);
    rd_raw(1'b1, v);
  endtask

  task automatic put(logic [7:0] i, logic [7:0] d);
    wr(1'b0, i);
    wr(1'b1, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 time_load", {7'd0, time_load}, 8'h00);
    rd_idx(8'd10, v); chk("R1 A", v, 8'h26);
    rd_idx(8'd11, v); chk("R1 B", v, 8'h02);
    rd_idx(8'd12, v); chk("R1 C", v, 8'h00);
    rd_idx(8'd13, v); chk("R1 D", v, 8'h80);
    chk("R11 ctl_b", ctl_b, 8'h02);
    chk("R4 rate_sel", {4'd0, rate_sel}, 8'h06);
    chk("R4 osc_sel", {5'd0, osc_sel}, 8'h02);
  endtask

  task automatic t_index;
    logic [7:0] v;
    put(8'h8E, 8'h5A);
    rd_idx(8'd14, v); chk("R2 index bit7 ignored", v, 8'h5A);
    rd_raw(1'b0, v); chk("R2 even read", v, 8'hFF);
  endtask

  task automatic t_storage;
    logic [7:0] v;
    put(8'd1, 8'h11); put(8'd3, 8'hC3); put(8'd5, 8'hA5); put(8'd127, 8'h7E);
    rd_idx(8'd1, v);   chk("R3 idx1", v, 8'h11);
    rd_idx(8'd3, v);   chk("R3 idx3", v, 8'hC3);
    rd_idx(8'd5, v);   chk("R3 idx5", v, 8'hA5);
    rd_idx(8'd127, v); chk("R3 idx127", v, 8'h7E);
  endtask

  task automatic t_reg_a;
    logic [7:0] v;
    @(negedge clk); uset = 1'b1; @(negedge clk); uset = 1'b0;
    rd_idx(8'd10, v); chk("R5 uip_set", v, 8'hA6);
    put(8'd10, 8'h2B);
    rd_idx(8'd10, v); chk("R4 A keeps uip 1", v, 8'hAB);
    chk("R4 rate_sel", {4'd0, rate_sel}, 8'h0B);
    @(negedge clk); uclr = 1'b1; @(negedge clk); uclr = 1'b0;
    put(8'd10, 8'hA6);
    rd_idx(8'd10, v); chk("R4 A keeps uip 0", v, 8'h26);
  endtask

  task automatic t_set_mode;
    logic [7:0] v;
    @(negedge clk); uset = 1'b1; @(negedge clk); uset = 1'b0;
    put(8'd11, 8'h82);
    chk("R11 ctl_b", ctl_b, 8'h82);
    rd_idx(8'd10, v); chk("R5 SET clears uip", v, 8'h26);
    @(negedge clk); uset = 1'b1; @(negedge clk); uset = 1'b0;
    rd_idx(8'd10, v); chk("R5 uip_set blocked", v, 8'h26);
    put(8'd0, 8'h30);
    chk("R10 no load in SET", {7'd0, time_load}, 8'h00);
    wr(1'b0, 8'd11);
    wr(1'b1, 8'h02);
    chk("R10 load on SET clear", {7'd0, time_load}, 8'h01);
    @(negedge clk);
    chk("R10 one pulse", {7'd0, time_load}, 8'h00);
    wr(1'b0, 8'd7);
    wr(1'b1, 8'h15);
    chk("R10 load on date write", {7'd0, time_load}, 8'h01);
    put(8'd1, 8'h22);
    chk("R10 no load alarm", {7'd0, time_load}, 8'h00);
  endtask

  task automatic t_cd_ignore;
    logic [7:0] v;
    put(8'd12, 8'hFF);
    chk("R6 irq after C write", {7'd0, irq}, 8'h00);
    rd_idx(8'd12, v); chk("R6 C write ignored", v, 8'h00);
    put(8'd13, 8'h00);
    rd_idx(8'd13, v); chk("R6 D write ignored", v, 8'h80);
  endtask

  task automatic t_flags;
    logic [7:0] v;
    @(negedge clk); fset = 3'b100; @(negedge clk); fset = 3'b000;
    chk("R7 no irq disabled", {7'd0, irq}, 8'h00);
    rd_idx(8'd12, v); chk("R7 periodic flag", v, 8'h40);
    rd_idx(8'd12, v); chk("R8 cleared", v, 8'h00);
    put(8'd11, 8'h22);
    @(negedge clk); fset = 3'b010; @(negedge clk); fset = 3'b000;
    chk("R7 irq alarm", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'd12);
    rd_raw(1'b1, v); chk("R8 read value", v, 8'hA0);
    chk("R8 irq dropped", {7'd0, irq}, 8'h00);
    put(8'd11, 8'h12);
    @(negedge clk); fset = 3'b001; @(negedge clk); fset = 3'b000;
    chk("R7 irq update", {7'd0, irq}, 8'h01);
    rd_idx(8'd12, v); chk("R7 update flag", v, 8'h90);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    put(8'd11, 8'h42);
    @(negedge clk); fset = 3'b001; @(negedge clk); fset = 3'b000;
    wr(1'b0, 8'd12);
    @(negedge clk); a0 = 1'b1; rd = 1'b1; fset = 3'b100;
    @(negedge clk); rd = 1'b0; fset = 3'b000; v = rdata;
    chk("R9 read excludes new", v, 8'h10);
    chk("R9 irq kept", {7'd0, irq}, 8'h01);
    rd_raw(1'b1, v); chk("R9 kept for next", v, 8'hC0);
    rd_raw(1'b1, v); chk("R8 clear after", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_storage();
    t_reg_a();
    t_set_mode();
    t_cd_ignore();
    t_flags();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule